// File: doc/BRIEF.md
# Bus Initiator Transaction Sequencer

This block is the initiator end of a shared, multiplexed address/data bus. A local user hands it one transaction at a time: a 64-bit address, a 4-bit command, a direction and a word count. The block then asks the arbiter for the bus and waits for the grant. It drives the address, and runs the data phases until the count is used up or one side ends the transfer. When the transaction finishes it reports how it ended and how many words actually moved.

The address phase is picked from the address itself. When the upper 32 bits are all zero, one address cycle carries the low word and the real command. Otherwise two cycles are used. The first carries the low word with a reserved dual-address command, and the second carries the high word with the real command. Write data and byte enables come from the user port for the word index the block presents. Read data is returned with disabled bytes cleared. A target that never claims the address leads to a master abort.

Top module: `busInitiator`

## Requirements
- R1: After a request is accepted in idle, `busReq` is high from the next cycle until `busGnt` is sampled high. No address cycle (`frameOut`, `adOe`) appears before that. The first address cycle follows the cycle in which the grant was sampled.
- R2: When `reqAddr[63:32]` is zero there is exactly one address cycle. It has `frameOut`=1, `adOe`=1, `adOut`=`reqAddr[31:0]` and `cbeOut`=`reqCmd`, and the data phase starts in the next cycle.
- R3: When `reqAddr[63:32]` is nonzero, the first address cycle drives `reqAddr[31:0]` with `cbeOut`=4'b1101. The second drives `reqAddr[63:32]` with `cbeOut`=`reqCmd`, and data phases follow.
- R4: A data phase completes only in a cycle with `irdyOut`, `trdyIn` and `devselIn` all high. `reqLen` words are moved (0 counts as 1), and `wordIdx` advances by one per completed phase.
- R5: In a write data phase `adOe`=1, `adOut`=`wrData` and `cbeOut`=~`userByteEn` (the enables are active low on the bus). `frameOut` is low in the final phase.
- R6: In a read data phase `adOe`=0. One cycle after each completed phase `rdValid` pulses, and `rdData` holds the bytes of `adIn` whose `userByteEn` bit was set, with the other bytes zero.
- R7: `stopIn` together with `devselIn` ends the transaction after that cycle. The word counts if `trdyIn` was high too. The status is 1 (target stop), or 0 when that word was the last one.
- R8: With `userStop` high, `frameOut` is low in the data phase. The phase that completes then ends the transaction with status 3 (initiator stop).
- R9: If `devselIn` is low in all 5 cycles that follow the last address cycle, the transaction ends with status 2 (master abort) and a count of 0. A claim in the fifth cycle still proceeds.
- R10: The cycle after the final data cycle is a turnaround cycle. In it `frameOut`, `irdyOut`, `adOe` and `busReq` are low, and `done`=1 with `doneStatus` and `doneCount` valid. The next cycle is idle.
- R11: After reset all bus outputs, `busy`, `done` and `rdValid` are low.
- R12: `irdyOut` follows ~`userWait` in a data phase. A paused phase does not complete even with `trdyIn` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a transaction (taken when idle) |
| reqAddr | input | 64 | Transaction address |
| reqCmd | input | 4 | Command code |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqLen | input | LEN_W | Word count |
| wordIdx | output | LEN_W | Index of the word in the current data phase / words completed |
| wrData | input | 32 | Write data for `wordIdx` |
| userByteEn | input | 4 | Active-high byte enables for `wordIdx` |
| userWait | input | 1 | Pause the initiator (drops `irdyOut`) |
| userStop | input | 1 | Make the current phase the last one |
| rdValid | output | 1 | Read word valid |
| rdData | output | 32 | Read word, disabled bytes zero |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | Turnaround cycle, results valid |
| doneStatus | output | 2 | 0 ok, 1 target stop, 2 master abort, 3 initiator stop |
| doneCount | output | LEN_W | Words completed |
| busReq | output | 1 | Bus request to the arbiter |
| busGnt | input | 1 | Grant from the arbiter |
| frameOut | output | 1 | Transaction framing, low in the final phase |
| irdyOut | output | 1 | Initiator ready |
| adOe | output | 1 | Address/data output enable |
| adOut | output | 32 | Address/data out |
| adIn | input | 32 | Address/data in |
| cbeOut | output | 4 | Command or active-low byte enables |
| devselIn | input | 1 | Target claims the transaction |
| trdyIn | input | 1 | Target ready |
| stopIn | input | 1 | Target requests stop |

## Verification
Bus outputs depend only on the state register and on the live pause and stop inputs. They are due in the cycle after the edge that enters a state: `busReq` one cycle after acceptance, the first address cycle one cycle after the grant is sampled, and the first data phase one or two cycles after that. `rdValid`/`rdData` and the `done` results come one edge after the completing data cycle. The abort comes on the edge that ends the fifth unclaimed data cycle. The bench drives all inputs on the falling edge and checks each output at a fixed cycle counted from its stimulus, so every check lands on exactly one cycle and never on a clock edge.

// File: rtl/initPkg.sv
package initPkg;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_ADDR_LO, S_ADDR_HI, S_DATA, S_TURN
  } seqState_e;

  typedef enum logic [1:0] {
    PH_NONE, PH_ADDR_LO, PH_ADDR_HI, PH_DATA
  } busPhase_e;

  typedef enum logic [1:0] {
    TS_OK = 2'd0, TS_TGT_STOP = 2'd1, TS_ABORT = 2'd2, TS_INIT_STOP = 2'd3
  } termStat_e;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;
  localparam logic [3:0]  DUAL_CMD = 4'b1101;

  typedef struct packed {
    logic      load;
    logic      wordInc;
    logic      rdCap;
    logic      finish;
    termStat_e stat;
    busPhase_e phase;
  } ctlStrobe_t;

endpackage

// File: rtl/initDatapath.sv
module initDatapath
  import initPkg::*;
#(
  parameter int unsigned MAX_WORDS   = 16,
  parameter int unsigned CLAIM_LIMIT = 5,
  localparam int unsigned LEN_W      = $clog2(MAX_WORDS + 1),
  localparam int unsigned CLAIM_W    = $clog2(CLAIM_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [63:0]       reqAddr,
  input  logic [3:0]        reqCmd,
  input  logic              reqWrite,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [WORD_W-1:0] wrData,
  input  logic [LANES-1:0]  userByteEn,
  input  logic [WORD_W-1:0] adIn,
  input  logic              devselIn,
  output logic              isDual,
  output logic              lastWord,
  output logic              claimTimeout,
  output logic              wrQ,
  output logic [LEN_W-1:0]  wordIdx,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdData,
  output logic [1:0]        doneStatus,
  output logic              adOe,
  output logic [WORD_W-1:0] adOut,
  output logic [3:0]        cbeOut
);

  logic [63:0]        addrQ;
  logic [3:0]         cmdQ;
  logic [LEN_W-1:0]   lenQ;
  logic [LEN_W-1:0]   wordCnt;
  logic [CLAIM_W-1:0] claimCnt;
  logic               claimed;
  termStat_e          statusQ;
  logic [LEN_W-1:0]   lenEff;

  always_comb begin
    if (reqLen == '0)
      lenEff = LEN_W'(1);
    else if (reqLen > LEN_W'(MAX_WORDS))
      lenEff = LEN_W'(MAX_WORDS);
    else
      lenEff = reqLen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      cmdQ  <= '0;
      wrQ   <= 1'b0;
      lenQ  <= LEN_W'(1);
    end else if (strobe.load) begin
      addrQ <= reqAddr;
      cmdQ  <= reqCmd;
      wrQ   <= reqWrite;
      lenQ  <= lenEff;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      wordCnt <= '0;
    else if (strobe.load)
      wordCnt <= '0;
    else if (strobe.wordInc)
      wordCnt <= wordCnt + LEN_W'(1);
  end

  // Claim window: counts data-phase cycles that pass with no target claim.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      claimCnt <= '0;
      claimed  <= 1'b0;
    end else if (strobe.load) begin
      claimCnt <= '0;
      claimed  <= 1'b0;
    end else if (strobe.phase == PH_DATA) begin
      if (devselIn)
        claimed <= 1'b1;
      else if (!claimed && claimCnt < CLAIM_W'(CLAIM_LIMIT))
        claimCnt <= claimCnt + CLAIM_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      statusQ <= TS_OK;
    else if (strobe.finish)
      statusQ <= strobe.stat;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      rdValid <= 1'b0;
    else
      rdValid <= strobe.rdCap;
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : g_rdLane
    always_ff @(posedge clk) begin
      if (!rstN)
        rdData[lane*8 +: 8] <= '0;
      else if (strobe.rdCap)
        rdData[lane*8 +: 8] <= userByteEn[lane] ? adIn[lane*8 +: 8] : 8'h00;
    end
  end

  assign isDual       = (addrQ[63:32] != 32'd0);
  assign lastWord     = (wordCnt == lenQ - LEN_W'(1));
  assign claimTimeout = !claimed && !devselIn && (claimCnt == CLAIM_W'(CLAIM_LIMIT - 1));
  assign wordIdx      = wordCnt;
  assign doneStatus   = statusQ;

  always_comb begin
    adOe   = 1'b0;
    adOut  = '0;
    cbeOut = '0;
    case (strobe.phase)
      PH_ADDR_LO: begin
        adOe   = 1'b1;
        adOut  = addrQ[31:0];
        cbeOut = isDual ? DUAL_CMD : cmdQ;
      end
      PH_ADDR_HI: begin
        adOe   = 1'b1;
        adOut  = addrQ[63:32];
        cbeOut = cmdQ;
      end
      PH_DATA: begin
        adOe   = wrQ;
        adOut  = wrQ ? wrData : '0;
        cbeOut = ~userByteEn;
      end
      default: ;
    endcase
  end

  AST_WORD_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.phase == PH_DATA) |-> (wordCnt < lenQ)); // R4

  AST_CLAIM_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.phase == PH_DATA && !claimed) |-> (claimCnt < CLAIM_W'(CLAIM_LIMIT))); // R9

  AST_RD_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !wrQ); // R6

endmodule

// File: rtl/initCtrl.sv
module initCtrl
  import initPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       busGnt,
  input  logic       devselIn,
  input  logic       trdyIn,
  input  logic       stopIn,
  input  logic       userWait,
  input  logic       userStop,
  input  logic       isDual,
  input  logic       lastWord,
  input  logic       claimTimeout,
  input  logic       wrQ,
  output ctlStrobe_t strobe,
  output logic       busReq,
  output logic       frameOut,
  output logic       irdyOut,
  output logic       busy,
  output logic       done
);

  seqState_e state, stateNxt;
  logic      xfer;

  always_ff @(posedge clk) begin
    if (!rstN)
      state <= S_IDLE;
    else
      state <= stateNxt;
  end

  assign xfer = (state == S_DATA) && !userWait && trdyIn && devselIn;

  always_comb begin
    stateNxt = state;
    strobe   = '{load: 1'b0, wordInc: 1'b0, rdCap: 1'b0, finish: 1'b0,
                 stat: TS_OK, phase: PH_NONE};
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          strobe.load = 1'b1;
          stateNxt    = S_REQ;
        end
      end
      S_REQ: begin
        if (busGnt)
          stateNxt = S_ADDR_LO;
      end
      S_ADDR_LO: begin
        strobe.phase = PH_ADDR_LO;
        stateNxt     = isDual ? S_ADDR_HI : S_DATA;
      end
      S_ADDR_HI: begin
        strobe.phase = PH_ADDR_HI;
        stateNxt     = S_DATA;
      end
      S_DATA: begin
        strobe.phase   = PH_DATA;
        strobe.wordInc = xfer;
        strobe.rdCap   = xfer && !wrQ;
        if (claimTimeout) begin
          strobe.finish = 1'b1;
          strobe.stat   = TS_ABORT;
          stateNxt      = S_TURN;
        end else if (devselIn && stopIn) begin
          strobe.finish = 1'b1;
          strobe.stat   = (xfer && lastWord) ? TS_OK : TS_TGT_STOP;
          stateNxt      = S_TURN;
        end else if (xfer && lastWord) begin
          strobe.finish = 1'b1;
          strobe.stat   = TS_OK;
          stateNxt      = S_TURN;
        end else if (xfer && userStop) begin
          strobe.finish = 1'b1;
          strobe.stat   = TS_INIT_STOP;
          stateNxt      = S_TURN;
        end
      end
      S_TURN: stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  assign busReq   = (state == S_REQ);
  assign frameOut = (state == S_ADDR_LO) || (state == S_ADDR_HI) ||
                    ((state == S_DATA) && !lastWord && !userStop);
  assign irdyOut  = (state == S_DATA) && !userWait;
  assign busy     = (state != S_IDLE);
  assign done     = (state == S_TURN);

  AST_FRAME_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameOut) |-> $past(busReq && busGnt)); // R1

  AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ADDR_HI) |-> ($past(state == S_ADDR_LO) && isDual)); // R3

  AST_NO_DUAL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ADDR_LO && !isDual) |=> (state == S_DATA)); // R2

  AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DATA && userWait) |-> !strobe.wordInc); // R12

  AST_TURN_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TURN) |=> (state == S_IDLE && !frameOut && !irdyOut)); // R10

endmodule

// File: rtl/busInitiator.sv
module busInitiator
  import initPkg::*;
#(
  parameter int unsigned MAX_WORDS   = 16,
  parameter int unsigned CLAIM_LIMIT = 5,
  localparam int unsigned LEN_W      = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [63:0]       reqAddr,
  input  logic [3:0]        reqCmd,
  input  logic              reqWrite,
  input  logic [LEN_W-1:0]  reqLen,
  output logic [LEN_W-1:0]  wordIdx,
  input  logic [31:0]       wrData,
  input  logic [3:0]        userByteEn,
  input  logic              userWait,
  input  logic              userStop,
  output logic              rdValid,
  output logic [31:0]       rdData,
  output logic              busy,
  output logic              done,
  output logic [1:0]        doneStatus,
  output logic [LEN_W-1:0]  doneCount,
  output logic              busReq,
  input  logic              busGnt,
  output logic              frameOut,
  output logic              irdyOut,
  output logic              adOe,
  output logic [31:0]       adOut,
  input  logic [31:0]       adIn,
  output logic [3:0]        cbeOut,
  input  logic              devselIn,
  input  logic              trdyIn,
  input  logic              stopIn
);

  ctlStrobe_t strobe;
  logic       isDual;
  logic       lastWord;
  logic       claimTimeout;
  logic       wrQ;

  initCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .busGnt       (busGnt),
    .devselIn     (devselIn),
    .trdyIn       (trdyIn),
    .stopIn       (stopIn),
    .userWait     (userWait),
    .userStop     (userStop),
    .isDual       (isDual),
    .lastWord     (lastWord),
    .claimTimeout (claimTimeout),
    .wrQ          (wrQ),
    .strobe       (strobe),
    .busReq       (busReq),
    .frameOut     (frameOut),
    .irdyOut      (irdyOut),
    .busy         (busy),
    .done         (done)
  );

  initDatapath #(
    .MAX_WORDS   (MAX_WORDS),
    .CLAIM_LIMIT (CLAIM_LIMIT)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqAddr      (reqAddr),
    .reqCmd       (reqCmd),
    .reqWrite     (reqWrite),
    .reqLen       (reqLen),
    .wrData       (wrData),
    .userByteEn   (userByteEn),
    .adIn         (adIn),
    .devselIn     (devselIn),
    .isDual       (isDual),
    .lastWord     (lastWord),
    .claimTimeout (claimTimeout),
    .wrQ          (wrQ),
    .wordIdx      (wordIdx),
    .rdValid      (rdValid),
    .rdData       (rdData),
    .doneStatus   (doneStatus),
    .adOe         (adOe),
    .adOut        (adOut),
    .cbeOut       (cbeOut)
  );

  assign doneCount = wordIdx;

endmodule

// File: tb/sim_busInitiator.sv
module sim_busInitiator;

  localparam int LEN_W = 5;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic [63:0]      reqAddr = '0;
  logic [3:0]       reqCmd = '0;
  logic             reqWrite = 1'b0;
  logic [LEN_W-1:0] reqLen = '0;
  logic [LEN_W-1:0] wordIdx;
  logic [31:0]      wrData;
  logic [3:0]       userByteEn = 4'hF;
  logic             userWait = 1'b0;
  logic             userStop = 1'b0;
  logic             rdValid;
  logic [31:0]      rdData;
  logic             busy, done;
  logic [1:0]       doneStatus;
  logic [LEN_W-1:0] doneCount;
  logic             busReq;
  logic             busGnt = 1'b1;
  logic             frameOut, irdyOut, adOe;
  logic [31:0]      adOut;
  logic [31:0]      adIn = '0;
  logic [3:0]       cbeOut;
  logic             devselIn = 1'b0, trdyIn = 1'b0, stopIn = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  assign wrData = 32'hA0B0C000 + 32'(wordIdx);

  busInitiator u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqCmd(reqCmd),
    .reqWrite(reqWrite), .reqLen(reqLen), .wordIdx(wordIdx), .wrData(wrData),
    .userByteEn(userByteEn), .userWait(userWait), .userStop(userStop),
    .rdValid(rdValid), .rdData(rdData), .busy(busy), .done(done),
    .doneStatus(doneStatus), .doneCount(doneCount), .busReq(busReq), .busGnt(busGnt),
    .frameOut(frameOut), .irdyOut(irdyOut), .adOe(adOe), .adOut(adOut), .adIn(adIn),
    .cbeOut(cbeOut), .devselIn(devselIn), .trdyIn(trdyIn), .stopIn(stopIn)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  // Issue a request with the grant already high; returns in the first data cycle.
  task automatic toData(input logic [63:0] addr, input logic [3:0] cmd,
                        input logic wr, input int len);
    nxt();
    reqValid = 1'b1; reqAddr = addr; reqCmd = cmd; reqWrite = wr;
    reqLen = LEN_W'(len); busGnt = 1'b1;
    #1;
    nxt();
    reqValid = 1'b0;
    #1;
    chk("R1 busReq", busReq, 1'b1);
    chk("R1 no frame before grant", frameOut, 1'b0);
    nxt(); #1;
    chk("R2/R3 frame in addr", frameOut, 1'b1);
    chk("R2/R3 adOe in addr", adOe, 1'b1);
    chk("R2/R3 low addr", adOut, addr[31:0]);
    if (addr[63:32] != 32'd0) begin
      chk("R3 dual cmd", cbeOut, 4'b1101);
      nxt(); #1;
      chk("R3 high addr", adOut, addr[63:32]);
      chk("R3 real cmd", cbeOut, cmd);
    end else begin
      chk("R2 single cmd", cbeOut, cmd);
    end
    nxt();
  endtask

  task automatic expectEnd(input string req, input logic [1:0] stat, input int cnt);
    nxt();
    devselIn = 1'b0; trdyIn = 1'b0; stopIn = 1'b0; userStop = 1'b0; userWait = 1'b0;
    #1;
    chk({req, " R10 done"}, done, 1'b1);
    chk({req, " status"}, doneStatus, stat);
    chk({req, " count"}, doneCount, LEN_W'(cnt));
    chk("R10 turn idle bus", {frameOut, irdyOut, adOe, busReq}, 4'b0000);
    nxt(); #1;
    chk("R10 back idle", {done, busy}, 2'b00);
  endtask

  task automatic testReset();
    #1;
    chk("R11 reset outputs", {busReq, frameOut, irdyOut, adOe, busy, done, rdValid}, 7'd0);
  endtask

  task automatic testGrantSingleWrite();
    nxt();
    busGnt = 1'b0; reqValid = 1'b1; reqAddr = 64'h0000_0000_1234_5678;
    reqCmd = 4'h7; reqWrite = 1'b1; reqLen = LEN_W'(1); userByteEn = 4'b0011;
    #1;
    nxt(); reqValid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (i == 2) busGnt = 1'b1;
      #1;
      chk("R1 hold request", busReq, 1'b1);
      chk("R1 no address before grant", {frameOut, adOe}, 2'b00);
      nxt();
    end
    #1;
    chk("R2 addr", adOut, 32'h1234_5678);
    chk("R2 cmd", cbeOut, 4'h7);
    chk("R1 request dropped", busReq, 1'b0);
    nxt();
    devselIn = 1'b1; trdyIn = 1'b1;
    #1;
    chk("R2 data right after single addr", irdyOut, 1'b1);
    chk("R5 write data", adOut, 32'hA0B0C000);
    chk("R5 active-low enables", cbeOut, 4'b1100);
    chk("R5 frame low in final phase", frameOut, 1'b0);
    chk("R5 adOe", adOe, 1'b1);
    expectEnd("R4", 2'd0, 1);
  endtask

  task automatic testDualRead();
    userByteEn = 4'b0101;
    toData(64'h0000_0001_8000_0010, 4'h6, 1'b0, 3);
    devselIn = 1'b1; trdyIn = 1'b1; adIn = 32'h1122_3344;
    #1;
    chk("R6 no drive on read", adOe, 1'b0);
    chk("R6 read enables", cbeOut, 4'b1010);
    chk("R5 frame mid burst", frameOut, 1'b1);
    nxt(); adIn = 32'h5566_7788; #1;
    chk("R6 rdValid", rdValid, 1'b1);
    chk("R6 masked word0", rdData, 32'h0022_0044);
    nxt(); adIn = 32'h99AA_BBCC; #1;
    chk("R6 masked word1", rdData, 32'h0066_0088);
    chk("R4 last phase frame low", frameOut, 1'b0);
    nxt(); devselIn = 1'b0; trdyIn = 1'b0; #1;
    chk("R6 masked word2", rdData, 32'h00AA_00CC);
    chk("R10 done after read", done, 1'b1);
    chk("R4 three words", doneCount, LEN_W'(3));
    chk("R4 status ok", doneStatus, 2'd0);
    nxt(); #1;
    chk("R6 rdValid ends", rdValid, 1'b0);
    userByteEn = 4'hF;
  endtask

  task automatic testPause();
    toData(64'h0000_0000_0000_0100, 4'h7, 1'b1, 2);
    devselIn = 1'b1; trdyIn = 1'b1; userWait = 1'b1;
    #1;
    chk("R12 irdy low when paused", irdyOut, 1'b0);
    nxt(); userWait = 1'b0; trdyIn = 1'b0; #1;
    chk("R12 paused phase not done", wordIdx, LEN_W'(0));
    chk("R12 irdy back", irdyOut, 1'b1);
    nxt(); trdyIn = 1'b1; #1;
    chk("R4 no target-ready no advance", adOut, 32'hA0B0C000);
    nxt(); #1;
    chk("R4 advanced", wordIdx, LEN_W'(1));
    chk("R5 word1 data", adOut, 32'hA0B0C001);
    expectEnd("R4", 2'd0, 2);
  endtask

  task automatic testTargetStop();
    toData(64'h0000_0000_0000_0200, 4'h7, 1'b1, 4);
    devselIn = 1'b1; trdyIn = 1'b1; stopIn = 1'b1;
    expectEnd("R7 stop with data", 2'd1, 1);
    toData(64'h0000_0000_0000_0300, 4'h7, 1'b1, 4);
    devselIn = 1'b1; trdyIn = 1'b1;
    nxt(); nxt(); trdyIn = 1'b0; stopIn = 1'b1;
    expectEnd("R7 stop without data", 2'd1, 2);
    toData(64'h0000_0000_0000_0400, 4'h7, 1'b1, 1);
    devselIn = 1'b1; trdyIn = 1'b1; stopIn = 1'b1;
    expectEnd("R7 stop on last word", 2'd0, 1);
  endtask

  task automatic testInitStop();
    toData(64'h0000_0000_0000_0500, 4'h7, 1'b1, 4);
    devselIn = 1'b1; trdyIn = 1'b1; userStop = 1'b1;
    #1;
    chk("R8 frame low on stop", frameOut, 1'b0);
    chk("R8 irdy still high", irdyOut, 1'b1);
    expectEnd("R8", 2'd3, 1);
  endtask

  task automatic testAbort();
    toData(64'h0000_0000_FFFF_FFFC, 4'h7, 1'b1, 2);
    for (int c = 0; c < 5; c++) begin
      #1;
      chk("R9 waiting for claim", done, 1'b0);
      if (c < 4) nxt();
    end
    expectEnd("R9 abort", 2'd2, 0);
    toData(64'h0000_0000_0000_0600, 4'h7, 1'b1, 1);
    for (int c = 0; c < 4; c++) nxt();
    devselIn = 1'b1; trdyIn = 1'b1;
    expectEnd("R9 late claim", 2'd0, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    @(negedge clk); rstN = 1'b1;
    testGrantSingleWrite();
    testDualRead();
    testPause();
    testTargetStop();
    testInitStop();
    testAbort();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule